// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one channel of a classic programmable interval timer: a down-counter of parameterised width (16 bits by default) that advances on a count-enable strobe issued at the timer input rate. A load strobe delivers an operating mode, a binary/BCD selector and an initial count in a single cycle. The channel then shapes its output waveform according to that mode: a terminal-count flag, a gate-triggered one-shot, a rate divider, a square wave, or a software- or gate-triggered strobe. The live count value goes to a host-side register interface, which reads it. Bus decoding, count latching and interrupt routing are left to surrounding logic.

The gate input has two roles. In the rate-divider, square-wave, terminal-count and software-strobe modes, a low gate pauses counting. In the one-shot, rate-divider, square-wave and gate-strobe modes, a rising edge on the gate restarts the count from the stored initial value. An initial count of zero stands for the largest period. Non-periodic modes let the counter roll over past zero. Periodic modes reload instead.

Top module: `ict_channel`

## Requirements
- R1: After reset, `count` is 0 and `out` is low, and strobes on `cnt_en` do not move the count until a load arrives.
- R2: On a clock edge with `load` high, `count` takes `load_val` and the mode is taken from `load_mode`. Mode codes 6 and 7 behave exactly as 2 and 3.
- R3: A stored count of 0 stands for the full range. One tick from 0 gives all-ones (0xFFFF) in binary and 0x9999 in BCD. In the square-wave mode, 0 stands for a period of 65536 ticks in binary and 10000 ticks in BCD.
- R4: In modes 0, 1, 4 and 5, a tick at count 0 in binary wraps the count to 0xFFFF and counting continues.
- R5: With `load_bcd` set, each 4-bit digit of `count` (digit 0 in bits 3:0) counts down from 9 to 0 and borrows from the next digit. A tick at 0x0010 gives 0x0009, and a tick at 0x0000 gives 0x9999.
- R6: Mode 0 (terminal flag): `out` is low from the load, goes high on the tick that takes the count from 1 to 0, and stays high until the next load.
- R7: Mode 1 (one-shot): after a load, the count holds and `out` stays high until a gate rising edge. From that edge `out` is low, and it goes high on the tick that takes the count from 1 to 0.
- R8: Mode 2 (rate divider): `out` is low while the count is 1. The next tick reloads the initial count and `out` returns high.
- R9: Mode 3 (square wave): with N the count value, `out` is high for the first ceil(N/2) ticks of each N-tick period and low for the rest. The count reloads after N ticks.
- R10: Modes 4 and 5 (strobes): `out` is low for exactly one tick interval, from the tick that takes the count from 1 to 0 until the next tick, and only once per load or trigger. Mode 5 starts counting only after a gate rising edge.
- R11: In modes 0, 2, 3 and 4, ticks have no effect while `gate` is low. In modes 1 and 5, the gate level does not stop counting.
- R12: In modes 1, 2, 3 and 5, a gate rising edge reloads the count from the initial value. In modes 0 and 4, a rising edge leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_en | input | 1 | Count-enable strobe, one cycle per timer input tick |
| gate | input | 1 | Gate input: level enable and rising-edge trigger |
| load | input | 1 | Load strobe for mode, BCD flag and initial count |
| load_mode | input | 3 | Operating mode code 0 to 7 |
| load_bcd | input | 1 | 1 selects BCD counting, 0 binary |
| load_val | input | W (16) | Initial count, 0 meaning full range |
| count | output | W (16) | Live count value |
| out | output | 1 | Mode-shaped output waveform |

## Verification
Every result is due on the clock edge that samples the causing input: a load, a tick, or a gate transition. `count` and `out` change on that same edge, because `out` is decoded without a further register stage from state updated there. The bench changes inputs just after a falling edge and lets exactly one rising edge pass per stimulus. It then reads the outputs at the next falling edge, so every expectation is placed at a latency of one edge. After reset is released, the bench also waits out the two-edge release synchroniser before the first check.

// File: rtl/ict_pkg.sv
package ict_pkg;

  typedef enum logic [2:0] {
    M_TERM    = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTB   = 3'd4,
    M_HWSTB   = 3'd5
  } mode_e;

  // codes 6 and 7 alias the two periodic modes
  function automatic mode_e norm_mode(input logic [2:0] code);
    if (code[2:1] == 2'b11) return mode_e'({1'b0, code[1:0]});
    return mode_e'(code);
  endfunction

  function automatic logic is_periodic(input mode_e m);
    return (m == M_RATE) || (m == M_SQUARE);
  endfunction

  function automatic logic edge_restarts(input mode_e m);
    return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HWSTB);
  endfunction

  function automatic logic level_gated(input mode_e m);
    return (m == M_TERM) || (m == M_RATE) || (m == M_SQUARE) || (m == M_SWSTB);
  endfunction

endpackage

// File: rtl/ict_decr.sv
module ict_decr #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic         bcd,
  output logic [W-1:0] res
);
  localparam int D = W / 4;

  logic [D-1:0] brw;
  logic [W-1:0] bres;

  assign brw[0] = 1'b1;

  for (genvar g = 0; g < D; g++) begin : g_dig
    logic [3:0] dg;
    assign dg = val[4*g +: 4];
    assign bres[4*g +: 4] = !brw[g] ? dg : ((dg == 4'd0) ? 4'd9 : dg - 4'd1);
    if (g < D - 1) begin : g_chain
      assign brw[g+1] = brw[g] & (dg == 4'd0);
    end
  end

  assign res = bcd ? bres : (val - W'(1));

endmodule

// File: rtl/ict_numval.sv
module ict_numval #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic         bcd,
  output logic [W:0]   half
);
  localparam int D = W / 4;

  logic [W:0] acc;
  logic [W:0] wt;
  logic [W:0] nval;

  always_comb begin
    acc = '0;
    wt  = (W+1)'(1);
    for (int d = 0; d < D; d++) begin
      acc = acc + (W+1)'(val[4*d +: 4]) * wt;
      wt  = wt * (W+1)'(10);
    end
    if (bcd) nval = (acc == '0) ? wt : acc;
    else     nval = (val == '0) ? ((W+1)'(1) << W) : {1'b0, val};
    half = (nval + (W+1)'(1)) >> 1;
  end

endmodule

// File: rtl/ict_channel.sv
module ict_channel
  import ict_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         gate,
  input  logic         load,
  input  logic [2:0]   load_mode,
  input  logic         load_bcd,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         out
);

  logic rs1, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1     <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rs1     <= 1'b1;
      rst_s_n <= rs1;
    end
  end

  mode_e        mode_q, mode_n;
  logic         bcd_q, bcd_n;
  logic [W-1:0] init_q, init_n;
  logic [W-1:0] cnt_q, cnt_n;
  logic [W:0]   ph_q, ph_n;
  logic         armed_q, armed_n;
  logic         fired_q, fired_n;
  logic         strobe_q, strobe_n;
  logic         gate_q;

  logic [W-1:0] cnt_dec;
  logic [W:0]   half;
  logic         gate_rise, step;
  mode_e        load_m;

  ict_decr #(.W(W)) u_decr (.val(cnt_q), .bcd(bcd_q), .res(cnt_dec));
  ict_numval #(.W(W)) u_half (.val(init_q), .bcd(bcd_q), .half(half));

  assign gate_rise = gate & ~gate_q;
  assign step      = cnt_en & armed_q & (gate | ~level_gated(mode_q));
  assign load_m    = norm_mode(load_mode);

  always_comb begin
    mode_n   = mode_q;
    bcd_n    = bcd_q;
    init_n   = init_q;
    cnt_n    = cnt_q;
    ph_n     = ph_q;
    armed_n  = armed_q;
    fired_n  = fired_q;
    strobe_n = strobe_q;
    if (load) begin
      mode_n   = load_m;
      bcd_n    = load_bcd;
      init_n   = load_val;
      cnt_n    = load_val;
      ph_n     = '0;
      fired_n  = 1'b0;
      strobe_n = 1'b0;
      armed_n  = (load_m != M_ONESHOT) && (load_m != M_HWSTB);
    end else if (gate_rise && edge_restarts(mode_q)) begin
      cnt_n    = init_q;
      ph_n     = '0;
      armed_n  = 1'b1;
      fired_n  = 1'b0;
      strobe_n = 1'b0;
    end else if (step) begin
      if (is_periodic(mode_q)) begin
        if (cnt_q == W'(1)) begin
          cnt_n = init_q;
          ph_n  = '0;
        end else begin
          cnt_n = cnt_dec;
          ph_n  = ph_q + (W+1)'(1);
        end
      end else begin
        cnt_n    = cnt_dec;
        strobe_n = (cnt_q == W'(1)) && !fired_q;
        if (cnt_q == W'(1)) fired_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      mode_q   <= M_TERM;
      bcd_q    <= 1'b0;
      init_q   <= '0;
      cnt_q    <= '0;
      ph_q     <= '0;
      armed_q  <= 1'b0;
      fired_q  <= 1'b0;
      strobe_q <= 1'b0;
      gate_q   <= 1'b0;
    end else begin
      mode_q   <= mode_n;
      bcd_q    <= bcd_n;
      init_q   <= init_n;
      cnt_q    <= cnt_n;
      ph_q     <= ph_n;
      armed_q  <= armed_n;
      fired_q  <= fired_n;
      strobe_q <= strobe_n;
      gate_q   <= gate;
    end
  end

  always_comb begin
    unique case (mode_q)
      M_TERM:    out = fired_q;
      M_ONESHOT: out = !armed_q || fired_q;
      M_RATE:    out = !(armed_q && (cnt_q == W'(1)));
      M_SQUARE:  out = ph_q < half;
      default:   out = !strobe_q;
    endcase
  end

  assign count = cnt_q;

endmodule

// File: rtl/ict_channel_chk.sv
module ict_channel_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_s_n,
  input logic         load,
  input logic [W-1:0] load_val,
  input logic [2:0]   mode_q,
  input logic         bcd_q,
  input logic [W-1:0] init_q,
  input logic         step,
  input logic         gate_rise,
  input logic [W-1:0] count,
  input logic         out
);

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    load |=> (count == $past(load_val)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!load && !gate_rise && !step) |=> $stable(count));

  // R12
  retrigger_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!load && gate_rise && (mode_q == 3'd1 || mode_q == 3'd2 || mode_q == 3'd3 || mode_q == 3'd5))
    |=> (count == $past(init_q)));

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!load && !gate_rise && step && !bcd_q && count == '0 && mode_q != 3'd2 && mode_q != 3'd3)
    |=> (count == '1));

  // R6
  term_sticky_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!load && mode_q == 3'd0 && out) |=> out);

  // R8
  rate_reload_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!load && !gate_rise && step && mode_q == 3'd2 && count == W'(1))
    |=> (count == $past(init_q) && out));

  // R10
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!load && !gate_rise && mode_q == 3'd4 && !out && step) |=> out);

endmodule

bind ict_channel ict_channel_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_s_n   (rst_s_n),
  .load      (load),
  .load_val  (load_val),
  .mode_q    (mode_q),
  .bcd_q     (bcd_q),
  .init_q    (init_q),
  .step      (step),
  .gate_rise (gate_rise),
  .count     (count),
  .out       (out)
);

// File: tb/sim_ict_channel.sv
`timescale 1ns/100ps
module sim_ict_channel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        gate = 1'b0;
  logic        load = 1'b0;
  logic [2:0]  load_mode = 3'd0;
  logic        load_bcd = 1'b0;
  logic [15:0] load_val = 16'd0;
  logic [15:0] count;
  logic        out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ict_channel #(.W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gate(gate), .load(load),
    .load_mode(load_mode), .load_bcd(load_bcd), .load_val(load_val),
    .count(count), .out(out)
  );

  // {mode, bcd, init, ticks, expected count, expected out}
  localparam int NV = 16;
  localparam logic [44:0] VEC [NV] = '{
    {3'd0, 1'b0, 16'h0005, 8'd4, 16'h0001, 1'b0},
    {3'd0, 1'b0, 16'h0005, 8'd5, 16'h0000, 1'b1},
    {3'd0, 1'b0, 16'h0005, 8'd7, 16'hFFFE, 1'b1},
    {3'd0, 1'b1, 16'h0003, 8'd5, 16'h9998, 1'b1},
    {3'd2, 1'b0, 16'h0004, 8'd3, 16'h0001, 1'b0},
    {3'd2, 1'b0, 16'h0004, 8'd4, 16'h0004, 1'b1},
    {3'd3, 1'b0, 16'h0005, 8'd2, 16'h0003, 1'b1},
    {3'd3, 1'b0, 16'h0005, 8'd3, 16'h0002, 1'b0},
    {3'd3, 1'b0, 16'h0005, 8'd5, 16'h0005, 1'b1},
    {3'd4, 1'b0, 16'h0003, 8'd3, 16'h0000, 1'b0},
    {3'd4, 1'b0, 16'h0003, 8'd4, 16'hFFFF, 1'b1},
    {3'd7, 1'b0, 16'h0004, 8'd2, 16'h0002, 1'b0},
    {3'd6, 1'b0, 16'h0003, 8'd2, 16'h0001, 1'b0},
    {3'd2, 1'b1, 16'h0010, 8'd1, 16'h0009, 1'b1},
    {3'd0, 1'b0, 16'h0000, 8'd1, 16'hFFFF, 1'b0},
    {3'd1, 1'b0, 16'h0003, 8'd2, 16'h0003, 1'b1}
  };

  function automatic string vtag(input int i);
    case (i)
      0, 1:    return "R6";
      2:       return "R4";
      3:       return "R5";
      4, 5:    return "R8";
      6, 7, 8: return "R9";
      9, 10:   return "R10";
      11, 12:  return "R2";
      13:      return "R5";
      14:      return "R3";
      default: return "R7";
    endcase
  endfunction

  task automatic edge1();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_load(input logic [2:0] m, input logic b, input logic [15:0] v);
    load = 1'b1; load_mode = m; load_bcd = b; load_val = v;
    edge1();
    load = 1'b0;
  endtask

  task automatic do_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      cnt_en = 1'b1;
      edge1();
      cnt_en = 1'b0;
    end
  endtask

  task automatic set_gate(input logic g);
    gate = g;
    edge1();
  endtask

  task automatic chk(input string req, input logic [15:0] ec, input logic eo);
    checks++;
    if (count !== ec || out !== eo) begin
      fails++;
      $display("FAIL %s: count=%h out=%b expected count=%h out=%b", req, count, out, ec, eo);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete (R1 stimulus hung)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    edge1(); edge1(); edge1();
    // R1: reset state, ticks without a load move nothing
    chk("R1", 16'h0000, 1'b0);
    do_ticks(3);
    chk("R1", 16'h0000, 1'b0);

    set_gate(1'b1);
    for (int i = 0; i < NV; i++) begin
      do_load(VEC[i][44:42], VEC[i][41], VEC[i][40:25]);
      do_ticks(int'(VEC[i][24:17]));
      chk(vtag(i), VEC[i][16:1], VEC[i][0]);
    end

    // R6: a new load drops out in mode 0
    do_load(3'd0, 1'b0, 16'd5);
    do_ticks(5);
    chk("R6", 16'h0000, 1'b1);
    do_load(3'd0, 1'b0, 16'd9);
    chk("R6", 16'h0009, 1'b0);

    // R3: zero in BCD square wave is 10000 ticks, first tick gives 9999
    do_load(3'd3, 1'b1, 16'h0000);
    do_ticks(1);
    chk("R3", 16'h9999, 1'b1);

    // R7: one-shot waits for gate rise, ignores gate level, retriggers
    do_load(3'd1, 1'b0, 16'd3);
    set_gate(1'b0);
    set_gate(1'b1);
    chk("R7", 16'h0003, 1'b0);
    set_gate(1'b0);
    do_ticks(1);
    chk("R11", 16'h0002, 1'b0);
    set_gate(1'b1);
    chk("R12", 16'h0003, 1'b0);
    do_ticks(3);
    chk("R7", 16'h0000, 1'b1);

    // R10: gate strobe mode
    do_load(3'd5, 1'b0, 16'd2);
    do_ticks(2);
    chk("R10", 16'h0002, 1'b1);
    set_gate(1'b0);
    set_gate(1'b1);
    do_ticks(2);
    chk("R10", 16'h0000, 1'b0);
    do_ticks(1);
    chk("R10", 16'hFFFF, 1'b1);

    // R11: gate low pauses mode 0; R12: rise does not reload mode 0
    do_load(3'd0, 1'b0, 16'd5);
    do_ticks(2);
    set_gate(1'b0);
    do_ticks(3);
    chk("R11", 16'h0003, 1'b0);
    set_gate(1'b1);
    chk("R12", 16'h0003, 1'b0);
    do_ticks(1);
    chk("R11", 16'h0002, 1'b0);

    // R12: rate divider restarts on rise, mode 4 does not
    do_load(3'd2, 1'b0, 16'd6);
    do_ticks(3);
    set_gate(1'b0);
    set_gate(1'b1);
    chk("R12", 16'h0006, 1'b1);
    do_load(3'd4, 1'b0, 16'd5);
    do_ticks(2);
    set_gate(1'b0);
    set_gate(1'b1);
    chk("R12", 16'h0003, 1'b1);

    // R3: binary square wave with zero count
    do_load(3'd3, 1'b0, 16'h0000);
    do_ticks(1);
    chk("R3", 16'hFFFF, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule